// File: doc/BRIEF.md
# Five-Bit Teleprinter Serial Transmitter

This block turns 5-bit character codes into an asynchronous teleprinter line signal. A character is handed over on a valid/ready parallel port. The transmitter then sends one space start element and the five code bits, least significant bit first. It closes the character with a mark stop element that is longer than the others. While no character is being sent, the line rests at mark.

One element lasts a number of system clock cycles that a divide parameter sets. The stop element does not last a whole number of elements. It is 1.42 times one element, rounded to the nearest clock cycle when the design is elaborated. With the default divide of 20 cycles, the stop element lasts 28 cycles and a full character lasts 148 cycles. A character offered during the last stop cycle is taken at once, so characters can follow each other with no idle gap.

Top module: `tty5_serial_tx`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts `line_out` at mark (1), `busy` at 0 and `in_ready` at 1 from the next cycle on.
- R2: In the cycle after a handshake (`in_valid` and `in_ready` both high at a clock edge), `line_out` goes to space (0). It stays at space for exactly `CLKS_PER_ELEM` cycles, which is 20 by default.
- R3: Next come exactly five data elements, each `CLKS_PER_ELEM` cycles long. They carry `in_code[0]` first and `in_code[4]` last. A 1 bit is sent as mark and a 0 bit as space.
- R4: The stop element is mark and lasts round(1.42 × `CLKS_PER_ELEM`) cycles, which is 28 by default.
- R5: `in_ready` is low from the handshake until the last cycle of the stop element. A code offered while `in_ready` is low is not taken, and it never appears on the line.
- R6: If `in_valid` is high in the last stop cycle, the next start element begins in the very next cycle. Successive start elements are then 6 × `CLKS_PER_ELEM` + stop cycles apart, which is 148 by default.
- R7: `busy` is high in every cycle of a character, from its start element to the end of its stop element, and low when the line is idle.
- R8: A reset in the middle of a character ends it at once: the line returns to mark and `busy` drops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A character code is offered |
| in_ready | output | 1 | The transmitter can take a code at this edge |
| in_code | input | 5 | Character code; bit 0 is sent first |
| line_out | output | 1 | Serial line; 1 = mark, 0 = space |
| busy | output | 1 | A character is being sent |

## Verification
The case hardest to reach is the hand-off in the last stop cycle. Here `in_ready` is high for a single cycle at the very end of the fractional stop element, and the following start element must join the stop element with no gap. The driver reaches this case by queuing a second character with `in_valid` held high before the first one finishes. The monitor then measures the distance between the two start edges. A code offered in the middle of a character is held for several cycles, and the scoreboard confirms that it never reaches the line.

// File: rtl/tty5_tx_pkg.sv
package tty5_tx_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_START = 2'd1,
      PH_DATA  = 2'd2,
      PH_STOP  = 2'd3
   } phase_t;

   // Stop length in clock cycles: element length scaled by num/den, rounded to nearest.
   function automatic int stop_len(input int elem_clks, input int num, input int den);
      return (elem_clks * num + den / 2) / den;
   endfunction

endpackage

// File: rtl/tty5_elem_timer.sv
module tty5_elem_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             elem_done
);

   logic [CNT_W-1:0] cnt_q;

   assign elem_done = run && (cnt_q == limit - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst || !run || elem_done)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end

   // R4: the element counter never passes the current element length
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt_q < limit))
      else $error("element counter beyond limit");

endmodule

// File: rtl/tty5_shifter.sv
module tty5_shifter #(
   parameter int DATA_BITS = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] load_val,
   input  logic                 shift,
   output logic                 cur_bit
);

   logic [DATA_BITS-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst)
         sh_q <= '0;
      else if (load)
         sh_q <= load_val;
      else if (shift)
         sh_q <= {1'b0, sh_q[DATA_BITS-1:1]};
   end

   assign cur_bit = sh_q[0];

endmodule

// File: rtl/tty5_tx_ctrl.sv
module tty5_tx_ctrl
   import tty5_tx_pkg::*;
#(
   parameter int DATA_BITS = 5,
   parameter int CNT_W     = 5,
   parameter int ELEM_CLKS = 20,
   parameter int STOP_CLKS = 28
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             elem_done,
   input  logic             data_bit,
   output logic             in_ready,
   output logic             load,
   output logic             shift,
   output logic             run,
   output logic [CNT_W-1:0] limit,
   output logic             line_out,
   output logic             busy
);

   localparam int BC_W = $clog2(DATA_BITS + 1);

   phase_t          phase_q, phase_d;
   logic [BC_W-1:0] bit_q, bit_d;

   assign in_ready = (phase_q == PH_IDLE) || (phase_q == PH_STOP && elem_done);
   assign load     = in_valid && in_ready;
   assign shift    = (phase_q == PH_DATA) && elem_done;
   assign run      = (phase_q != PH_IDLE);
   assign busy     = run;
   assign limit    = (phase_q == PH_STOP) ? CNT_W'(STOP_CLKS) : CNT_W'(ELEM_CLKS);

   always_comb begin
      case (phase_q)
         PH_START: line_out = 1'b0;
         PH_DATA:  line_out = data_bit;
         default:  line_out = 1'b1;
      endcase
   end

   always_comb begin
      phase_d = phase_q;
      bit_d   = bit_q;
      case (phase_q)
         PH_IDLE:
            if (in_valid) phase_d = PH_START;
         PH_START:
            if (elem_done) begin
               phase_d = PH_DATA;
               bit_d   = '0;
            end
         PH_DATA:
            if (elem_done) begin
               if (bit_q == BC_W'(DATA_BITS - 1))
                  phase_d = PH_STOP;
               else
                  bit_d = bit_q + BC_W'(1);
            end
         PH_STOP:
            if (elem_done) phase_d = in_valid ? PH_START : PH_IDLE;
         default:
            phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         bit_q   <= '0;
      end else begin
         phase_q <= phase_d;
         bit_q   <= bit_d;
      end
   end

   // R1, R8: reset returns the line to mark and clears busy
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (line_out && !busy && in_ready))
      else $error("reset did not idle the line");

   // R2: a handshake is followed by space on the line
   a_r2_start_follows: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> (!line_out && busy))
      else $error("start element missing after handshake");

   // R3: the line only moves at element boundaries while busy
   a_r3_line_steady: assert property (@(posedge clk) disable iff (rst)
      (busy && !elem_done) |=> $stable(line_out))
      else $error("line changed inside an element");

   // R6: a code waiting at stop end starts at once
   a_r6_back_to_back: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_STOP && elem_done && in_valid) |=> (phase_q == PH_START))
      else $error("gap after stop with code waiting");

   // R5: no code taken mid character
   a_r5_no_mid_load: assert property (@(posedge clk) disable iff (rst)
      (busy && !(phase_q == PH_STOP && elem_done)) |-> !load)
      else $error("code taken while busy");

endmodule

// File: rtl/tty5_serial_tx.sv
module tty5_serial_tx
   import tty5_tx_pkg::*;
#(
   parameter int DATA_BITS     = 5,
   parameter int CLKS_PER_ELEM = 20,
   parameter int STOP_NUM      = 142,
   parameter int STOP_DEN      = 100
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [DATA_BITS-1:0] in_code,
   output logic                 line_out,
   output logic                 busy
);

   localparam int STOP_CLKS = stop_len(CLKS_PER_ELEM, STOP_NUM, STOP_DEN);
   localparam int MAX_CLKS  = (STOP_CLKS > CLKS_PER_ELEM) ? STOP_CLKS : CLKS_PER_ELEM;
   localparam int CNT_W     = $clog2(MAX_CLKS + 1);

   if (DATA_BITS < 1) begin : g_bad_width
      $error("DATA_BITS must be at least 1");
   end
   if (CLKS_PER_ELEM < 2) begin : g_bad_div
      $error("CLKS_PER_ELEM must be at least 2");
   end
   if (STOP_DEN < 1 || STOP_CLKS < 1) begin : g_bad_stop
      $error("stop ratio must give at least one cycle");
   end

   logic             elem_done, data_bit, load, shift, run;
   logic [CNT_W-1:0] limit;

   tty5_tx_ctrl #(
      .DATA_BITS (DATA_BITS),
      .CNT_W     (CNT_W),
      .ELEM_CLKS (CLKS_PER_ELEM),
      .STOP_CLKS (STOP_CLKS)
   ) ctrl_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .elem_done (elem_done),
      .data_bit  (data_bit),
      .in_ready  (in_ready),
      .load      (load),
      .shift     (shift),
      .run       (run),
      .limit     (limit),
      .line_out  (line_out),
      .busy      (busy)
   );

   tty5_elem_timer #(
      .CNT_W (CNT_W)
   ) timer_i (
      .clk       (clk),
      .rst       (rst),
      .run       (run),
      .limit     (limit),
      .elem_done (elem_done)
   );

   tty5_shifter #(
      .DATA_BITS (DATA_BITS)
   ) shift_i (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (in_code),
      .shift    (shift),
      .cur_bit  (data_bit)
   );

endmodule

// File: tb/tty5_serial_tx_tb_top.sv
`timescale 1ns/1ps
module tty5_serial_tx_tb_top;

   localparam int DIV   = 20;
   localparam int STOPC = 28;              // round(1.42 * 20) = round(28.4)
   localparam int FRAME = 6 * DIV + STOPC; // 148

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [4:0] in_code = '0;
   logic       in_ready, line_out, busy;

   int checks = 0;
   int failures = 0;
   int exp_q[$];
   int btb_q[$];

   always #10 clk = ~clk; // 50 MHz

   tty5_serial_tx dut_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_code  (in_code),
      .line_out (line_out),
      .busy     (busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // Monitor: rebuilds each frame from the scoreboard and compares every cycle
   bit in_frame = 0;
   int j = 0;
   int since = 100000;
   int cur_code = 0;
   int cur_btb = 0;
   bit frame_bad = 0;
   int bad_act = 0, bad_exp = 0, bad_j = 0;

   always @(negedge clk) begin
      if (rst) begin
         in_frame = 0;
         exp_q.delete();
         btb_q.delete();
         since = 100000;
      end else begin
         if (!in_frame && line_out == 1'b0) begin
            in_frame = 1;
            j = 0;
            frame_bad = 0;
            if (exp_q.size() == 0) begin
               check(0, "R5 unexpected frame", 1, 0);
               cur_code = 0;
               cur_btb = 0;
            end else begin
               cur_code = exp_q.pop_front();
               cur_btb  = btb_q.pop_front();
            end
            if (cur_btb != 0)
               check(since == FRAME, "R6 start spacing", since, FRAME);
            since = 0;
         end
         if (in_frame) begin
            int e;
            if (j < DIV) e = 0;                          // R2 start
            else if (j < 6 * DIV) e = (cur_code >> ((j - DIV) / DIV)) & 1; // R3 data
            else e = 1;                                  // R4 stop
            if (!frame_bad && (int'(line_out) != e || busy != 1'b1)) begin
               frame_bad = 1;
               bad_act = int'(line_out) + 2 * int'(busy);
               bad_exp = e + 2;
               bad_j = j;
            end
            j++;
            if (j == FRAME) begin
               in_frame = 0;
               if (frame_bad)
                  $display("  frame code=%0d mismatch at cycle %0d", cur_code, bad_j);
               check(!frame_bad, "R2 R3 R4 R7 frame waveform (line+2*busy)", bad_act, bad_exp);
            end
         end
         since++;
      end
   end

   // Driver: offers a code, waits for acceptance and records it in the scoreboard
   task automatic send(input int code, input int btb);
      @(negedge clk);
      in_code  = 5'(code);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      exp_q.push_back(code);
      btb_q.push_back(btb);
      @(posedge clk);
      #1 in_valid = 1'b0;
      @(negedge clk);
      check(line_out == 1'b0 && busy == 1'b1, "R2 R7 space after handshake",
            int'(line_out), 0);
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while ((busy || in_frame) && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check(!busy && line_out && in_ready, "R7 idle after frame", int'(busy), 0);
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(line_out == 1'b1 && busy == 1'b0 && in_ready == 1'b1, "R1 reset state",
            int'(line_out) + 2 * int'(busy), 1);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      check(line_out == 1'b1, "R1 idle mark after release", int'(line_out), 1);

      // R2 R3 R4: several bit patterns
      send(5'h15, 0); wait_idle();
      send(5'h0A, 0); wait_idle();
      send(5'h00, 0); wait_idle();
      send(5'h1F, 0); wait_idle();
      send(5'h01, 0); wait_idle();

      // R5: a code offered mid-character is ignored
      send(5'h13, 0);
      repeat (30) @(negedge clk);
      in_code  = 5'h0C;
      in_valid = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(in_ready == 1'b0, "R5 ready low mid character", int'(in_ready), 0);
      end
      in_valid = 1'b0;
      wait_idle();
      repeat (FRAME + 10) @(negedge clk);
      check(exp_q.size() == 0 && line_out == 1'b1, "R5 ignored code not sent",
            exp_q.size(), 0);

      // R6: back-to-back characters
      send(5'h06, 0);
      send(5'h19, 1);
      send(5'h10, 1);
      wait_idle();

      // R8: reset in the middle of a character
      send(5'h00, 0);
      repeat (50) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(line_out == 1'b1 && busy == 1'b0 && in_ready == 1'b1, "R8 reset mid character",
            int'(line_out) + 2 * int'(busy), 1);
      rst = 1'b0;
      repeat (FRAME) @(negedge clk);
      check(line_out == 1'b1 && busy == 1'b0, "R8 line stays mark after reset",
            int'(line_out), 1);

      send(5'h0E, 0); wait_idle();
      check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

endmodule